// File: doc/BRIEF.md
# Multi-rail fault supervisor

This block watches two switching regulators and one linear regulator through digital comparator flags, one per fault kind and rail, and turns them into control requests for the power stage. It owns a single fault latch that turns every converter off. It also issues a per-rail request to skip switching pulses while an overcurrent is being confirmed, and a per-rail request to hold the lower switch on while an output is too high. A single power-good output summarises the state of all rails.

The analog comparators, the soft-start ramp and the gate drivers sit outside. The block receives one tick per switching cycle, a soft-start-done flag, the core reference code with a transition-in-progress flag, an enable, a supply-good flag and an over-temperature flag. `drv_en_o` low tells the soft-start circuit to discharge, so every restart runs a full ramp.

Top module: `rail_fault_sup`

## Requirements
- R1: When the drivers are enabled and `oc_i[i]` is seen while rail i is idle, `skip_o[i]` goes high at the next clock edge and stays high for the confirmation window of `OC_TICKS` (default 8) asserted ticks. With the drivers disabled, no window starts.
- R2: At the edge that carries the last tick of the window, rail i leaves the window and `skip_o[i]` falls. If `oc_i[i]` is still high at that edge, `fault_o` rises at the same edge. Otherwise no fault is raised, and a later overcurrent starts a new window. Clock edges without a tick do not advance the window.
- R3: Once the drivers are enabled and `ss_done_i` is high, an undervoltage flag on any rail sets `fault_o` at the next edge, with `drv_en_o` and `pwr_ok_o` low. Before soft start is done, undervoltage flags are ignored.
- R4: `force_low_o[i]` follows `ov_i[i]` one clock later, gated by `enable_i` high and `ot_i` low. It is not latched and does not touch `fault_o`.
- R5: While `code_chg_i` is high, the core-rail undervoltage flag `uv_i[0]` is ignored. Flags for the other rails still act.
- R6: `pwr_ok_o` is high only when all of these hold: the drivers are on, no fault is latched, `ss_done_i` is high after a fresh soft start, both non-core windows in `win_i` are good, the core window is good, and the code is not a no-load code. The no-load codes are the two codes whose four low bits are all ones (01111 and 11111).
- R7: The core window is cleared by `core_above_hi_i`. It is set by `core_above_rise_i`. It is cleared when `core_above_fall_i` drops. Otherwise it holds its value, which gives the lower threshold hysteresis.
- R8: `fault_o` holds until a rising edge of `enable_i`. While `enable_i` is low, `drv_en_o` is low one clock later.
- R9: `ot_i` drops `drv_en_o` and `pwr_ok_o` one clock later. After `ot_i` or any other driver-off condition clears, `pwr_ok_o` stays low until `ss_done_i` has been seen low and then high again.
- R10: While `supply_ok_i` is low, the fault latch, the confirmation windows and all outputs return to their reset values at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Controller supply above its start level |
| enable_i | input | 1 | Chip enable; a rising edge clears the fault latch |
| ot_i | input | 1 | Over-temperature flag |
| tick_i | input | 1 | One pulse per switching cycle |
| ss_done_i | input | 1 | Soft-start ramp complete |
| code_i | input | CODE_W | Core reference code |
| code_chg_i | input | 1 | Core reference transition in progress |
| oc_i | input | NUM_SW | Overcurrent flag per switching rail |
| uv_i | input | NUM_RAIL | Undervoltage flag per rail; bit 0 is the core rail |
| ov_i | input | NUM_SW | Overvoltage flag per switching rail |
| win_i | input | NUM_RAIL-1 | In-window flag for the non-core rails |
| core_above_hi_i | input | 1 | Core output above its upper window threshold |
| core_above_rise_i | input | 1 | Core output above the rising lower threshold |
| core_above_fall_i | input | 1 | Core output above the falling lower threshold |
| fault_o | output | 1 | Global fault latch |
| skip_o | output | NUM_SW | Pulse-skip request per switching rail |
| force_low_o | output | NUM_SW | Lower-switch-on request per switching rail |
| drv_en_o | output | 1 | Converters and drivers allowed to run |
| pwr_ok_o | output | 1 | Power-good indication |

## Verification
Every output is a register that takes inputs sampled at one rising edge. Its effect is therefore due exactly one edge after the stimulus, except for the overcurrent decision, which falls on the edge that carries the eighth tick after the window opened. The bench changes inputs just after a falling edge and compares all outputs at the following falling edge. This places each comparison one register stage after its stimulus. The overcurrent sequences count ticks explicitly, including edges without a tick, so that the window length is checked and not assumed.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic {
    OC_IDLE = 1'b0,
    OC_WAIT = 1'b1
  } oc_st_e;
endpackage

// File: rtl/rfs_oc_filter.sv
module rfs_oc_filter #(
  parameter int unsigned OC_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic tick_i,
  input  logic oc_i,
  output logic skip_o,
  output logic confirm_o
);
  import rfs_pkg::*;

  localparam int unsigned CW = (OC_TICKS > 2) ? $clog2(OC_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OC_TICKS - 1);

  oc_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    confirm_o = 1'b0;
    if (!arm_i) begin
      st_d  = OC_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        OC_IDLE: begin
          if (oc_i) begin
            st_d  = OC_WAIT;
            cnt_d = '0;
          end
        end
        OC_WAIT: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              confirm_o = oc_i;
              st_d      = OC_IDLE;
              cnt_d     = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = OC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OC_IDLE;
      cnt_q <= '0;
    end else if (clr_i) begin
      st_q  <= OC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign skip_o = (st_q == OC_WAIT);
endmodule

// File: rtl/rfs_fault_ctl.sv
module rfs_fault_ctl #(
  parameter int unsigned NUM_SW   = 2,
  parameter int unsigned NUM_RAIL = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                enable_i,
  input  logic                ot_i,
  input  logic                ss_done_i,
  input  logic                code_chg_i,
  input  logic [NUM_RAIL-1:0] uv_i,
  input  logic [NUM_SW-1:0]   ov_i,
  input  logic [NUM_SW-1:0]   oc_hit_i,
  output logic                fault_o,
  output logic                drv_en_o,
  output logic                drv_en_d_o,
  output logic [NUM_SW-1:0]   force_low_o
);
  logic                fault_q, fault_d, en_q, drv_en_q;
  logic [NUM_SW-1:0]   force_q, force_d;
  logic [NUM_RAIL-1:0] uv_live;
  logic                uv_arm, fault_set, en_rise;

  // core rail (bit 0) is blind while its reference moves
  for (genvar r = 0; r < NUM_RAIL; r++) begin : g_uv
    if (r == 0) begin : g_core
      assign uv_live[r] = uv_i[r] & ~code_chg_i;
    end else begin : g_aux
      assign uv_live[r] = uv_i[r];
    end
  end

  assign uv_arm     = drv_en_q & ss_done_i;
  assign fault_set  = (uv_arm & (|uv_live)) | (|oc_hit_i);
  assign en_rise    = enable_i & ~en_q;
  assign fault_d    = fault_set | (fault_q & ~en_rise);
  assign drv_en_d_o = enable_i & ~ot_i & ~fault_d;
  assign force_d    = ov_i & {NUM_SW{enable_i & ~ot_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      en_q     <= 1'b0;
      drv_en_q <= 1'b0;
      force_q  <= '0;
    end else if (clr_i) begin
      fault_q  <= 1'b0;
      en_q     <= 1'b0;
      drv_en_q <= 1'b0;
      force_q  <= '0;
    end else begin
      fault_q  <= fault_d;
      en_q     <= enable_i;
      drv_en_q <= drv_en_d_o;
      force_q  <= force_d;
    end
  end

  assign fault_o     = fault_q;
  assign drv_en_o    = drv_en_q;
  assign force_low_o = force_q;
endmodule

// File: rtl/rfs_pwr_ok.sv
module rfs_pwr_ok #(
  parameter int unsigned NUM_RAIL = 3,
  parameter int unsigned CODE_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                drv_en_d_i,
  input  logic                ss_done_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [NUM_RAIL-2:0] win_i,
  input  logic                core_hi_i,
  input  logic                core_rise_i,
  input  logic                core_fall_i,
  output logic                pwr_ok_o
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic core_ok_q, core_ok_d, ss_arm_q, ss_arm_d, ok_q, ok_d, no_load;

  // low bits all ones => no load attached, top bit is don't-care
  assign no_load = ((code_i | MSB_ONLY) == {CODE_W{1'b1}});

  always_comb begin
    core_ok_d = core_ok_q;
    if (core_hi_i)        core_ok_d = 1'b0;
    else if (core_rise_i) core_ok_d = 1'b1;
    else if (!core_fall_i) core_ok_d = 1'b0;
  end

  // a fresh ramp must be seen (done low) after every driver-off period
  always_comb begin
    ss_arm_d = ss_arm_q;
    if (!drv_en_d_i)     ss_arm_d = 1'b0;
    else if (!ss_done_i) ss_arm_d = 1'b1;
  end

  assign ok_d = drv_en_d_i & ss_arm_q & ss_done_i & core_ok_d & (&win_i) & ~no_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_ok_q <= 1'b0;
      ss_arm_q  <= 1'b0;
      ok_q      <= 1'b0;
    end else if (clr_i) begin
      core_ok_q <= 1'b0;
      ss_arm_q  <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      core_ok_q <= core_ok_d;
      ss_arm_q  <= ss_arm_d;
      ok_q      <= ok_d;
    end
  end

  assign pwr_ok_o = ok_q;
endmodule

// File: rtl/rail_fault_sup.sv
module rail_fault_sup #(
  parameter int unsigned NUM_SW   = 2,
  parameter int unsigned NUM_RAIL = 3,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned OC_TICKS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                supply_ok_i,
  input  logic                enable_i,
  input  logic                ot_i,
  input  logic                tick_i,
  input  logic                ss_done_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                code_chg_i,
  input  logic [NUM_SW-1:0]   oc_i,
  input  logic [NUM_RAIL-1:0] uv_i,
  input  logic [NUM_SW-1:0]   ov_i,
  input  logic [NUM_RAIL-2:0] win_i,
  input  logic                core_above_hi_i,
  input  logic                core_above_rise_i,
  input  logic                core_above_fall_i,
  output logic                fault_o,
  output logic [NUM_SW-1:0]   skip_o,
  output logic [NUM_SW-1:0]   force_low_o,
  output logic                drv_en_o,
  output logic                pwr_ok_o
);
  logic              clr;
  logic              drv_en_d;
  logic [NUM_SW-1:0] oc_hit;

  assign clr = ~supply_ok_i;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_oc
    rfs_oc_filter #(.OC_TICKS(OC_TICKS)) u_oc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .arm_i    (drv_en_o),
      .tick_i   (tick_i),
      .oc_i     (oc_i[i]),
      .skip_o   (skip_o[i]),
      .confirm_o(oc_hit[i])
    );
  end

  rfs_fault_ctl #(.NUM_SW(NUM_SW), .NUM_RAIL(NUM_RAIL)) u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .enable_i   (enable_i),
    .ot_i       (ot_i),
    .ss_done_i  (ss_done_i),
    .code_chg_i (code_chg_i),
    .uv_i       (uv_i),
    .ov_i       (ov_i),
    .oc_hit_i   (oc_hit),
    .fault_o    (fault_o),
    .drv_en_o   (drv_en_o),
    .drv_en_d_o (drv_en_d),
    .force_low_o(force_low_o)
  );

  rfs_pwr_ok #(.NUM_RAIL(NUM_RAIL), .CODE_W(CODE_W)) u_pok (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .drv_en_d_i (drv_en_d),
    .ss_done_i  (ss_done_i),
    .code_i     (code_i),
    .win_i      (win_i),
    .core_hi_i  (core_above_hi_i),
    .core_rise_i(core_above_rise_i),
    .core_fall_i(core_above_fall_i),
    .pwr_ok_o   (pwr_ok_o)
  );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned NUM_SW   = 2,
  parameter int unsigned NUM_RAIL = 3,
  parameter int unsigned CODE_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                supply_ok_i,
  input logic                enable_i,
  input logic                ot_i,
  input logic                ss_done_i,
  input logic [CODE_W-1:0]   code_i,
  input logic                code_chg_i,
  input logic [NUM_SW-1:0]   oc_i,
  input logic [NUM_RAIL-1:0] uv_i,
  input logic [NUM_SW-1:0]   ov_i,
  input logic                core_above_hi_i,
  input logic                fault_o,
  input logic [NUM_SW-1:0]   skip_o,
  input logic [NUM_SW-1:0]   force_low_o,
  input logic                drv_en_o,
  input logic                pwr_ok_o
);
  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    AST_SKIP_ON_OC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oc_i[i] && drv_en_o && !skip_o[i] && supply_ok_i) |=> skip_o[i]); // R1
    AST_SKIP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!drv_en_o && !skip_o[i]) |=> !skip_o[i]); // R1
    AST_OV_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ov_i[i] && enable_i && !ot_i && supply_ok_i) |=> force_low_o[i]); // R4
    AST_OV_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ov_i[i] |=> !force_low_o[i]); // R4
  end

  AST_UV_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|uv_i[NUM_RAIL-1:1]) && drv_en_o && ss_done_i && supply_ok_i) |=> fault_o); // R3
  AST_CORE_UV_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_chg_i && uv_i[0] && uv_i[NUM_RAIL-1:1] == '0 && !fault_o && skip_o == '0)
      |=> !fault_o); // R5
  AST_PG_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ok_o |-> (drv_en_o && !fault_o)); // R6
  AST_NO_LOAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&code_i[CODE_W-2:0]) |=> !pwr_ok_o); // R6
  AST_CORE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_above_hi_i |=> !pwr_ok_o); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && supply_ok_i && !(enable_i && !$past(enable_i))) |=> fault_o); // R8
  AST_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !drv_en_o); // R8
  AST_OT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> (!drv_en_o && !pwr_ok_o)); // R9
  AST_SUPPLY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!fault_o && skip_o == '0 && !pwr_ok_o && !drv_en_o)); // R10
endmodule

bind rail_fault_sup rfs_checker #(
  .NUM_SW(NUM_SW), .NUM_RAIL(NUM_RAIL), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/rail_fault_sup_tb_top.sv
module rail_fault_sup_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sup, en, ot, tick, ss, chg, hi, rise, fall;
  logic [4:0] code;
  logic [1:0] oc, ov, win;
  logic [2:0] uv;
  logic       fault_o, drv_en_o, pwr_ok_o;
  logic [1:0] skip_o, force_low_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rail_fault_sup dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .enable_i(en), .ot_i(ot),
    .tick_i(tick), .ss_done_i(ss), .code_i(code), .code_chg_i(chg), .oc_i(oc),
    .uv_i(uv), .ov_i(ov), .win_i(win), .core_above_hi_i(hi),
    .core_above_rise_i(rise), .core_above_fall_i(fall), .fault_o(fault_o),
    .skip_o(skip_o), .force_low_o(force_low_o), .drv_en_o(drv_en_o), .pwr_ok_o(pwr_ok_o)
  );

  // in: sup en ot ss chg code[5] oc[2] uv[3] ov[2] win[2] hi rise fall
  // exp: fault skip[2] force[2] drv pg, then requirement number
  localparam int NV = 28;
  localparam logic [32:0] VEC [NV] = '{
    {22'b1_1_0_0_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd6},  // R6 ramp not done
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd6},  // R6 all good
    {22'b1_1_0_1_0_01111_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd6},  // R6 no-load code
    {22'b1_1_0_1_0_11111_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd6},  // R6 no-load code
    {22'b1_1_0_1_0_11110_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd6},  // R6 lowest code ok
    {22'b1_1_0_1_0_01010_00_000_00_10_0_1_1, 7'b0_00_00_1_0, 4'd6},  // R6 rail window out
    {22'b1_1_0_1_0_01010_00_000_00_11_0_0_1, 7'b0_00_00_1_1, 4'd7},  // R7 hysteresis hold
    {22'b1_1_0_1_0_01010_00_000_00_11_0_0_0, 7'b0_00_00_1_0, 4'd7},  // R7 below falling
    {22'b1_1_0_1_0_01010_00_000_00_11_0_0_1, 7'b0_00_00_1_0, 4'd7},  // R7 hold low
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd7},  // R7 above rising
    {22'b1_1_0_1_0_01010_00_000_00_11_1_1_1, 7'b0_00_00_1_0, 4'd7},  // R7 above upper
    {22'b1_1_0_1_0_01010_00_000_01_11_0_1_1, 7'b0_00_01_1_1, 4'd4},  // R4
    {22'b1_1_0_1_0_01010_00_000_11_11_0_1_1, 7'b0_00_11_1_1, 4'd4},  // R4
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd4},  // R4 release
    {22'b1_1_0_1_0_01010_00_000_10_11_0_1_1, 7'b0_00_10_1_1, 4'd4},  // R4
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd4},  // R4 release
    {22'b1_1_0_1_1_01010_00_001_00_11_0_1_1, 7'b0_00_00_1_1, 4'd5},  // R5 core uv masked
    {22'b1_1_0_1_1_01010_00_010_00_11_0_1_1, 7'b1_00_00_0_0, 4'd3},  // R3 io rail uv
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b1_00_00_0_0, 4'd8},  // R8 latched
    {22'b1_0_0_1_0_01010_00_000_00_11_0_1_1, 7'b1_00_00_0_0, 4'd8},  // R8 enable low
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd8},  // R8 rising clears
    {22'b1_1_0_0_0_01010_00_100_00_11_0_1_1, 7'b0_00_00_1_0, 4'd3},  // R3 not armed
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_1, 4'd6},  // R6 fresh ramp
    {22'b1_1_0_1_0_01010_00_001_00_11_0_1_1, 7'b1_00_00_0_0, 4'd3},  // R3 core uv
    {22'b0_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_0_0, 4'd10}, // R10 supply low
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd10}, // R10 back
    {22'b1_0_0_1_0_01010_00_000_01_11_0_1_1, 7'b0_00_00_0_0, 4'd4},  // R4 gated by enable
    {22'b1_1_0_1_0_01010_00_000_00_11_0_1_1, 7'b0_00_00_1_0, 4'd8}   // R8
  };

  task automatic set_nom();
    {sup, en, ot, ss, chg, code, oc, uv, ov, win, hi, rise, fall} =
      22'b1_1_0_1_0_01010_00_000_00_11_0_1_1;
    tick = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic f, input logic [1:0] sk, input logic [1:0] fl,
                     input logic drv, input logic pg, input int req, input string what);
    n_chk++;
    if ({fault_o, skip_o, force_low_o, drv_en_o, pwr_ok_o} !== {f, sk, fl, drv, pg}) begin
      n_fail++;
      $display("FAIL R%0d %s: got f=%b sk=%b fl=%b drv=%b pg=%b exp f=%b sk=%b fl=%b drv=%b pg=%b",
               req, what, fault_o, skip_o, force_low_o, drv_en_o, pwr_ok_o, f, sk, fl, drv, pg);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    set_nom();
    ss = 1'b0;
    repeat (3) @(negedge clk);
    chk(0, 2'b00, 2'b00, 0, 0, 10, "reset state R10");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {sup, en, ot, ss, chg, code, oc, uv, ov, win, hi, rise, fall} = VEC[i][32:11];
      step();
      chk(VEC[i][10], VEC[i][9:8], VEC[i][7:6], VEC[i][5], VEC[i][4],
          int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // fresh ramp so that power-good is up
    set_nom(); ss = 1'b0; step();
    ss = 1'b1; step();
    chk(0, 2'b00, 2'b00, 1, 1, 6, "ramp done R6");

    // R1 R2: overcurrent held through the window on rail 0, tick every clock
    oc = 2'b01; step();
    chk(0, 2'b01, 2'b00, 1, 1, 1, "skip starts R1");
    for (int k = 1; k <= 8; k++) begin
      step();
      if (k < 8) chk(0, 2'b01, 2'b00, 1, 1, 1, $sformatf("skip held tick %0d R1", k));
      else       chk(1, 2'b00, 2'b00, 0, 0, 2, "confirm at 8th tick R2");
    end

    // clear via enable edge
    oc = 2'b00; en = 1'b0; step();
    en = 1'b1; step();
    chk(0, 2'b00, 2'b00, 1, 0, 8, "cleared R8");

    // R2: rail 1, ticks on alternate clocks, overcurrent gone before last tick
    oc = 2'b10; tick = 1'b0; step();
    chk(0, 2'b10, 2'b00, 1, 0, 1, "skip starts rail1 R1");
    for (int k = 1; k <= 8; k++) begin
      tick = 1'b0; step();
      chk(0, 2'b10, 2'b00, 1, 0, 2, $sformatf("no tick no advance %0d R2", k));
      tick = 1'b1;
      if (k == 8) oc = 2'b00;
      step();
      if (k < 8) chk(0, 2'b10, 2'b00, 1, 0, 2, $sformatf("tick %0d R2", k));
      else       chk(0, 2'b00, 2'b00, 1, 0, 2, "recovered, no fault R2");
    end
    oc = 2'b10; step();
    chk(0, 2'b10, 2'b00, 1, 0, 2, "new window R2");
    oc = 2'b00;
    for (int k = 0; k < 8; k++) step();
    chk(0, 2'b00, 2'b00, 1, 0, 2, "second window recovered R2");

    // R9: over-temperature and forced fresh soft start
    ss = 1'b0; step();
    ss = 1'b1; step();
    chk(0, 2'b00, 2'b00, 1, 1, 9, "pg before OT R9");
    ot = 1'b1; step();
    chk(0, 2'b00, 2'b00, 0, 0, 9, "OT shuts down R9");
    ot = 1'b0; step();
    chk(0, 2'b00, 2'b00, 1, 0, 9, "restart without ramp R9");
    step();
    chk(0, 2'b00, 2'b00, 1, 0, 9, "still waiting ramp R9");
    ss = 1'b0; step();
    chk(0, 2'b00, 2'b00, 1, 0, 9, "ramp running R9");
    ss = 1'b1; step();
    chk(0, 2'b00, 2'b00, 1, 1, 9, "ramp done R9");

    done = 1'b1;
    finish_run();
  end
endmodule